// File: doc/BRIEF.md
# Tree-Structured Fair Arbiter with Bounded Wait

This block hands one shared resource, such as a bus, to one of `NUM_REQ` requesters at a time. Each requester raises its line in the request vector and holds it until it is served. Every cycle the block picks a winner among the raised lines. It returns the winner one cycle later as a one-hot grant vector, an encoded index and a valid flag.

The winner is found by a binary reduction tree of two-input arbitration cells rather than by one flat priority encoder. The rotation state of every cell lives in a separate fairness sub-block, so the selection tree and the rotation policy can be replaced or checked on their own. Each cell remembers which side it served last and favours the other side the next time both sides compete. This bounds how long a held request can wait.

A per-requester wait counter raises an error flag when any held request goes more than `WAIT_BOUND` cycles without a grant. The top level has a two-state phase machine with states PH_IDLE and PH_GRANT, which drives the valid flag. Its transitions are ISSUE (PH_IDLE to PH_GRANT, when some request is present), HOLD (stay in PH_GRANT while requests remain) and RELEASE (PH_GRANT to PH_IDLE, when the request vector is zero). Each fairness cell is a two-state machine with states PREF_LEFT and PREF_RIGHT. ROTATE_RIGHT moves it from PREF_LEFT to PREF_RIGHT after the cell serves its left side. ROTATE_LEFT moves it from PREF_RIGHT to PREF_LEFT after the cell serves its right side.

Top module: `fair_tree_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle.
- R2: `gnt[i]` is high only in the cycle right after a cycle in which `req[i]` was high; the grant latency is one cycle.
- R3: If any request bit is high in cycle t, exactly one grant is high in cycle t+1. If the request vector is all zero in cycle t, `gnt` is zero in cycle t+1.
- R4: `gnt_valid` equals the OR of `gnt`. `gnt_idx` is the bit position of the high `gnt` bit, and it is 0 when no grant is active.
- R5: The tree uses heap numbering. Node 1 is the root. Node k has children 2k (the lower-index half) and 2k+1 (the upper half). Requester i sits at leaf NUM_REQ+i. At each node on the path to the winner:
  - if only one side requests, that side wins;
  - if both sides request, the side the node did not serve last time wins;
  - a node that has not served since reset favours its left side.
  - With NUM_REQ=8 and all lines held from reset, the grant order is 0,4,2,6,1,5,3,7.
- R6: While `rst_n` is low, `gnt`, `gnt_idx` and `gnt_valid` are zero. Reset also returns every node preference to the left side.
- R7: A continuously held request sees at most NUM_REQ consecutive cycles with its request high and its grant low. With the default `WAIT_BOUND`, `starve_err` stays low.
- R8: `starve_err` goes high when some requester has had its request high and its grant low for more than `WAIT_BOUND` consecutive cycles. It returns low once no counter is over the bound. A counter restarts when its request drops or its grant arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_REQ | Request lines, one per requester |
| gnt | output | NUM_REQ | Registered one-hot grant |
| gnt_idx | output | $clog2(NUM_REQ) | Index of the granted requester |
| gnt_valid | output | 1 | A grant is active this cycle |
| starve_err | output | 1 | Some held request has waited past WAIT_BOUND |

## Verification
The assertions check the following on every cycle:
- mutual exclusion of grants;
- that a grant only follows a request one cycle earlier;
- that the arbiter never idles while requests are present;
- that the index and valid flag agree with the grant vector;
- through a wait counter of their own, that no held request waits more than NUM_REQ cycles.

Only the bench's scenarios can show the exact rotation order of the tree cells, the clearing of preferences by a reset in mid-traffic, and the error flag rising and clearing on an instance built with a deliberately tight bound.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Preference of a two-input tree cell: which child wins a tie.
    typedef enum logic {
        PREF_LEFT  = 1'b0,
        PREF_RIGHT = 1'b1
    } pref_e;

    // Top-level grant phase.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_GRANT = 1'b1
    } phase_e;

endpackage

// File: rtl/arb_node.sv
// Two-input arbitration cell: combines child request summaries and
// forwards the selection from its parent to one child.
module arb_node
    import arb_pkg::*;
(
    input  logic  left_req,
    input  logic  right_req,
    input  pref_e pref,
    input  logic  sel_in,
    output logic  any_req,
    output logic  sel_left,
    output logic  sel_right,
    output logic  took_right
);

    always_comb begin
        any_req    = left_req | right_req;
        took_right = right_req & (~left_req | (pref == PREF_RIGHT));
        sel_right  = sel_in & took_right;
        sel_left   = sel_in & left_req & ~took_right;
    end

endmodule

// File: rtl/arb_select_tree.sv
// Reduction tree of two-input cells. Heap numbering: node 1 is the root,
// node k has children 2k and 2k+1, requester i sits at leaf NUM_REQ+i.
module arb_select_tree
    import arb_pkg::*;
#(
    parameter int NUM_REQ = 8,
    localparam int NODES  = 2 * NUM_REQ
)(
    input  logic [NUM_REQ-1:0] req,
    input  logic [NUM_REQ-1:1] pref_vec,
    output logic [NUM_REQ-1:0] win_onehot,
    output logic [NUM_REQ-1:1] node_sel,
    output logic [NUM_REQ-1:1] node_right
);

    logic [NODES-1:1] up_any;
    logic [NODES-1:1] down_sel;

    // Leaves carry the raw request lines upward.
    for (genvar li = 0; li < NUM_REQ; li++) begin : g_leaf
        assign up_any[NUM_REQ + li] = req[li];
        assign win_onehot[li]       = down_sel[NUM_REQ + li];
    end

    // The root is selected whenever anything at all is requested.
    assign down_sel[1] = up_any[1];

    for (genvar k = 1; k < NUM_REQ; k++) begin : g_cell
        arb_node u_node (
            .left_req   (up_any[2*k]),
            .right_req  (up_any[2*k+1]),
            .pref       (pref_e'(pref_vec[k])),
            .sel_in     (down_sel[k]),
            .any_req    (up_any[k]),
            .sel_left   (down_sel[2*k]),
            .sel_right  (down_sel[2*k+1]),
            .took_right (node_right[k])
        );
        assign node_sel[k] = down_sel[k];
    end

endmodule

// File: rtl/arb_fair_ptrs.sv
// Fairness state: one two-state preference machine per tree cell.
// Kept apart from the selection tree so either can change on its own.
module arb_fair_ptrs
    import arb_pkg::*;
#(
    parameter int NUM_REQ = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:1] node_sel,
    input  logic [NUM_REQ-1:1] node_right,
    output logic [NUM_REQ-1:1] pref_vec
);

    for (genvar k = 1; k < NUM_REQ; k++) begin : g_ptr
        pref_e state_q;
        pref_e state_d;

        // State register.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= PREF_LEFT;
            end else begin
                state_q <= state_d;
            end
        end

        // Transitions: ROTATE_RIGHT after serving left, ROTATE_LEFT after right.
        always_comb begin
            state_d = state_q;
            unique case (state_q)
                PREF_LEFT: begin
                    if (node_sel[k] && !node_right[k]) begin
                        state_d = PREF_RIGHT;
                    end
                end
                PREF_RIGHT: begin
                    if (node_sel[k] && node_right[k]) begin
                        state_d = PREF_LEFT;
                    end
                end
                default: state_d = PREF_LEFT;
            endcase
        end

        assign pref_vec[k] = state_q;
    end

endmodule

// File: rtl/arb_wait_monitor.sv
// Per-requester count of consecutive cycles spent waiting; flags any
// count that passes the configured bound.
module arb_wait_monitor #(
    parameter int NUM_REQ    = 8,
    parameter int WAIT_BOUND = 8,
    localparam int CNT_W     = $clog2(WAIT_BOUND + 2)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    input  logic [NUM_REQ-1:0] gnt,
    output logic               starve_err
);

    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(WAIT_BOUND + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(WAIT_BOUND);

    logic [NUM_REQ-1:0] over;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_wait
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (req[i] && !gnt[i]) begin
                if (cnt_q != CNT_SAT) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end

        assign over[i] = (cnt_q > CNT_LIMIT);
    end

    assign starve_err = |over;

endmodule

// File: rtl/fair_tree_arbiter.sv
module fair_tree_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_REQ    = 8,
    parameter int WAIT_BOUND = NUM_REQ,
    localparam int IDX_W     = $clog2(NUM_REQ)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               gnt_valid,
    output logic               starve_err
);

    logic [NUM_REQ-1:1] pref_vec;
    logic [NUM_REQ-1:1] node_sel;
    logic [NUM_REQ-1:1] node_right;
    logic [NUM_REQ-1:0] win_onehot;
    logic [IDX_W-1:0]   win_idx;

    phase_e             phase_q;
    phase_e             phase_d;
    logic [NUM_REQ-1:0] gnt_q;
    logic [IDX_W-1:0]   idx_q;

    arb_select_tree #(.NUM_REQ(NUM_REQ)) u_tree (
        .req        (req),
        .pref_vec   (pref_vec),
        .win_onehot (win_onehot),
        .node_sel   (node_sel),
        .node_right (node_right)
    );

    arb_fair_ptrs #(.NUM_REQ(NUM_REQ)) u_fair (
        .clk        (clk),
        .rst_n      (rst_n),
        .node_sel   (node_sel),
        .node_right (node_right),
        .pref_vec   (pref_vec)
    );

    arb_wait_monitor #(.NUM_REQ(NUM_REQ), .WAIT_BOUND(WAIT_BOUND)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .gnt        (gnt_q),
        .starve_err (starve_err)
    );

    // Encode the one-hot winner.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (win_onehot[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

    // Phase transitions: ISSUE, HOLD, RELEASE.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  phase_d = (|req) ? PH_GRANT : PH_IDLE;
            PH_GRANT: phase_d = (|req) ? PH_GRANT : PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            gnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            gnt_q   <= win_onehot;
            idx_q   <= win_idx;
        end
    end

    assign gnt       = gnt_q;
    assign gnt_idx   = idx_q;
    assign gnt_valid = (phase_q == PH_GRANT);

endmodule

// File: rtl/fair_tree_arbiter_chk.sv
module fair_tree_arbiter_chk #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = 3
)(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req,
    input logic [NUM_REQ-1:0] gnt,
    input logic [IDX_W-1:0]   gnt_idx,
    input logic               gnt_valid,
    input logic               starve_err
);

    localparam int CW = $clog2(NUM_REQ + 2);

    assert_mutex_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_granted_had_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~$past(req)) == '0);

    assert_work_conserving_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(req)) |-> ($countones(gnt) == 1));

    assert_idle_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req) == '0) |-> (gnt == '0));

    assert_index_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt[gnt_idx] && (gnt_valid == (|gnt))));

    assert_index_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> ((gnt == '0) && (gnt_idx == '0)));

    // Independent wait counters for the bounded-wait guarantee (R7).
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_bound
        logic [CW-1:0] wc;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wc <= '0;
            end else if (req[i] && !gnt[i]) begin
                if (wc != CW'(NUM_REQ + 1)) begin
                    wc <= wc + 1'b1;
                end
            end else begin
                wc <= '0;
            end
        end

        assert_bounded_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wc <= CW'(NUM_REQ));
    end

    // starve_err is exercised by the bench (R8); observed here only as an input.
    logic unused_err;
    assign unused_err = starve_err;

endmodule

bind fair_tree_arbiter fair_tree_arbiter_chk #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .gnt        (gnt),
    .gnt_idx    (gnt_idx),
    .gnt_valid  (gnt_valid),
    .starve_err (starve_err)
);

// File: tb/fair_tree_arbiter_bench.sv
`timescale 1ns/1ps
module fair_tree_arbiter_bench;

    localparam int N     = 8;
    localparam int IW    = $clog2(N);
    localparam int LEVEL = IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  gnt, gnt_t;
    logic [IW-1:0] gnt_idx, gnt_idx_t;
    logic          gnt_valid, gnt_valid_t;
    logic          starve_err, starve_err_t;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    fair_tree_arbiter #(.NUM_REQ(N)) u_fair_tree_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
        .gnt_idx(gnt_idx), .gnt_valid(gnt_valid), .starve_err(starve_err)
    );

    // Second instance with a deliberately tight bound to exercise the flag.
    fair_tree_arbiter #(.NUM_REQ(N), .WAIT_BOUND(2)) u_fair_tree_arbiter_tight (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt_t),
        .gnt_idx(gnt_idx_t), .gnt_valid(gnt_valid_t), .starve_err(starve_err_t)
    );

    // Reference model state.
    logic [N-1:1]  ref_pref;
    logic [N-1:0]  exp_gnt;
    int            exp_idx;
    logic          exp_valid;
    logic [N-1:0]  last_req;
    int            wcnt [N];
    int            wmax;
    logic [31:0]   rng = 32'h1d2c_3b4a;

    task automatic check(input string tag, input bit ok, input string msg);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic int bitrev(input int v);
        int r = 0;
        for (int b = 0; b < LEVEL; b++) begin
            if (v[b]) r = r | (1 << (LEVEL - 1 - b));
        end
        return r;
    endfunction

    // Walk down from the root: one side wins alone, ties go to the side not
    // served last time, and the node then favours the other side.
    task automatic predict(input logic [N-1:0] r);
        int lo, span, node, half;
        bit l_any, r_any, go_r;
        if (r == '0) begin
            exp_gnt = '0; exp_idx = 0; exp_valid = 1'b0;
            return;
        end
        lo = 0; span = N; node = 1;
        while (span > 1) begin
            half = span / 2;
            l_any = 1'b0; r_any = 1'b0;
            for (int j = 0; j < half; j++) begin
                if (r[lo + j]) l_any = 1'b1;
                if (r[lo + half + j]) r_any = 1'b1;
            end
            go_r = r_any && (!l_any || ref_pref[node]);
            ref_pref[node] = !go_r;
            node = 2 * node + (go_r ? 1 : 0);
            if (go_r) lo = lo + half;
            span = half;
        end
        exp_gnt = N'(1) << lo; exp_idx = lo; exp_valid = 1'b1;
    endtask

    task automatic compare();
        check("R5", gnt == exp_gnt,
              $sformatf("gnt=%b expected %b", gnt, exp_gnt));
        check("R4", (gnt_idx == IW'(exp_idx)) && (gnt_valid == exp_valid),
              $sformatf("idx=%0d valid=%0b expected idx=%0d valid=%0b",
                        gnt_idx, gnt_valid, exp_idx, exp_valid));
        check("R7", starve_err == 1'b0,
              $sformatf("starve_err=%0b expected 0", starve_err));
        for (int i = 0; i < N; i++) begin
            if (last_req[i] && !gnt[i]) wcnt[i]++;
            else wcnt[i] = 0;
            if (wcnt[i] > wmax) wmax = wcnt[i];
        end
    endtask

    task automatic step(input logic [N-1:0] r, input bit in_rst);
        @(negedge clk);
        compare();
        rst_n = !in_rst;
        req   = r;
        if (in_rst) begin
            ref_pref = '0;
            exp_gnt = '0; exp_idx = 0; exp_valid = 1'b0;
            last_req = '0;
        end else begin
            predict(r);
            last_req = r;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        ref_pref = '0; exp_gnt = '0; exp_idx = 0; exp_valid = 1'b0;
        last_req = '0; wmax = 0;
        for (int i = 0; i < N; i++) wcnt[i] = 0;

        // R6: reset state.
        repeat (3) step('0, 1'b1);
        @(negedge clk);
        check("R6", (gnt == '0) && (gnt_idx == '0) && !gnt_valid,
              $sformatf("gnt=%b idx=%0d valid=%0b expected zero", gnt, gnt_idx, gnt_valid));
        check("R8", starve_err_t == 1'b0,
              $sformatf("tight starve_err=%0b expected 0", starve_err_t));

        // R5: all held from reset gives bit-reversed order.
        step('1, 1'b0);
        for (int k = 0; k < N; k++) begin
            step('1, 1'b0);
            check("R5", gnt_idx == IW'(bitrev(k)),
                  $sformatf("order slot %0d idx=%0d expected %0d", k, gnt_idx, bitrev(k)));
        end
        // R8: tight instance flags the long waits.
        for (int k = 0; k < 4; k++) step('1, 1'b0);
        check("R8", starve_err_t == 1'b1,
              $sformatf("tight starve_err=%0b expected 1", starve_err_t));

        // R3: idle vector gives no grant; counters clear.
        step('0, 1'b0);
        step('0, 1'b0);
        step('0, 1'b0);
        check("R3", (gnt == '0) && !gnt_valid,
              $sformatf("gnt=%b valid=%0b expected none", gnt, gnt_valid));
        check("R8", starve_err_t == 1'b0,
              $sformatf("tight starve_err=%0b expected 0 after idle", starve_err_t));

        // R2: single requester, then a dropped request.
        step(8'b0010_0000, 1'b0);
        step(8'b0000_0000, 1'b0);
        check("R2", gnt == 8'b0010_0000,
              $sformatf("gnt=%b expected 00100000", gnt));
        step('0, 1'b0);
        check("R2", gnt == '0, $sformatf("gnt=%b expected 0 after drop", gnt));

        // R5: siblings under one cell, and opposite halves.
        for (int k = 0; k < 6; k++) step(8'b0000_0011, 1'b0);
        for (int k = 0; k < 6; k++) step(8'b1000_0001, 1'b0);

        // R7: one line held while the rest toggle at random.
        wmax = 0;
        for (int k = 0; k < 300; k++) step(N'(rnd()) | 8'b0010_0000, 1'b0);
        step('0, 1'b0);
        check("R7", wmax <= N, $sformatf("max wait=%0d expected <= %0d", wmax, N));

        // R1..R5: fully random traffic including idle cycles.
        for (int k = 0; k < 400; k++) step(((rnd() & 3) == 0) ? '0 : N'(rnd()), 1'b0);

        // R6: reset during traffic restores left preferences.
        step('0, 1'b1);
        step('0, 1'b1);
        step('1, 1'b0);
        step('1, 1'b0);
        check("R6", gnt_idx == '0,
              $sformatf("first grant after reset idx=%0d expected 0", gnt_idx));
        step('1, 1'b0);
        check("R6", gnt_idx == IW'(N / 2),
              $sformatf("second grant after reset idx=%0d expected %0d", gnt_idx, N / 2));
        step('0, 1'b0);
        step('0, 1'b0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule